// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block connects an A-side bus and a B-side bus with one independent 18-bit path in each direction. Each path holds its data in a storage element that can behave as a transparent latch, as a closed latch, or as an edge-triggered register with an active-low capture enable. The control inputs choose among these behaviours from one sample to the next. Each path also has an active-low drive enable that decides whether the far bus is driven. The pins are split into separate input, output and drive-flag ports, so the surrounding logic or a testbench builds the high-impedance state.

The whole block runs on one internal sampling clock. The pass-through control and the external capture tick are sampled on that clock. A rising tick is a 0-to-1 change between two consecutive samples. Storage updates and drive flags are registered, so every effect is visible one sampling cycle after the inputs that cause it. A synchronous active-high reset clears both stores and withdraws both drive flags.

Top module: `dual_path_xcvr`

## Requirements
- R1: While a path's pass input is 1, that path's output equals the input data sampled one clock earlier, whatever its tick and tick-enable inputs do.
- R2: While pass is 0 and no rising tick is seen, the path's output keeps its previous value. A tick held steady at 0 or at 1, or a falling tick, changes nothing.
- R3: With pass at 0 and tick-enable (active low) at 0, a rising tick captures the input data of that sample. The captured value appears on the output one clock later.
- R4: While tick-enable is 1, rising ticks are ignored and the output holds its value.
- R5: A path's drive flag is 1 one clock after its drive-enable (active low) is sampled at 0, and 0 one clock after it is sampled at 1, independent of every other input.
- R6: The A-to-B and B-to-A paths store and drive independently. Activity on one path leaves the other path's output and drive flag unchanged.
- R7: When pass falls while the tick stays low, the path keeps the value from the last sample with pass at 1. If a rising tick with tick-enable at 0 lands in the same sample as the fall, the data of that sample is captured instead.
- R8: Reset clears both outputs to zero and both drive flags to 0 one clock after it is sampled high.
- R9: All 18 bits of a path move together under the same controls, with no bit crossing to another position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data arriving from the A-side bus |
| ab_pass | input | 1 | A-to-B pass-through (latch open when 1) |
| ab_tick | input | 1 | A-to-B external capture tick |
| ab_tick_en_n | input | 1 | A-to-B tick enable, active low |
| ab_drv_en_n | input | 1 | A-to-B drive enable, active low |
| b_out | output | 18 | Stored A-to-B value presented to the B bus |
| b_drive | output | 1 | 1 when the B bus is driven |
| b_in | input | 18 | Data arriving from the B-side bus |
| ba_pass | input | 1 | B-to-A pass-through (latch open when 1) |
| ba_tick | input | 1 | B-to-A external capture tick |
| ba_tick_en_n | input | 1 | B-to-A tick enable, active low |
| ba_drv_en_n | input | 1 | B-to-A drive enable, active low |
| a_out | output | 18 | Stored B-to-A value presented to the A bus |
| a_drive | output | 1 | 1 when the A bus is driven |

## Verification
The case that needs care is a fall of the pass input that lands in the same sample as a rising tick. There, the latch-hold rule and the edge-capture rule both apply at once. The bench opens the latch on one value, then in a single sample lowers pass, raises the tick and presents new data. With tick-enable at 0 it expects the new data on the output. It repeats the same sequence with tick-enable at 1 and then expects the older transparent value to stay.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 18;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_PASS = 2'd1,
    SRC_EDGE = 2'd2
  } cap_src_e;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R3
  rise_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !$past(lvl, 2) || $past(rst, 2));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         pass,
  input  logic         tick,
  input  logic         tick_en_n,
  input  logic         drv_en_n,
  output logic [W-1:0] dout,
  output logic         drive
);
  localparam logic [W-1:0] ZERO = '0;

  logic     tick_rise;
  cap_src_e src;
  logic [W-1:0] store_q;
  logic         drive_q;

  xcvr_edge_det u_tick_det (
    .clk  (clk),
    .rst  (rst),
    .lvl  (tick),
    .rise (tick_rise)
  );

  always_comb begin
    if (pass)                         src = SRC_PASS;
    else if (tick_rise && !tick_en_n) src = SRC_EDGE;
    else                              src = SRC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= ZERO;
    end else begin
      case (src)
        SRC_PASS, SRC_EDGE: store_q <= din;
        default:            store_q <= store_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= ~drv_en_n;
  end

  assign dout  = store_q;
  assign drive = drive_q;

  // R1
  pass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pass |=> dout == $past(din));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!pass && !tick_rise) |=> $stable(dout));

  // R3
  edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!pass && tick_rise && !tick_en_n) |=> dout == $past(din));

  // R4
  gated_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!pass && tick_en_n) |=> $stable(dout));

  // R5
  drive_off_chk: assert property (@(posedge clk) disable iff (rst)
    drv_en_n |=> !drive);

  // R5
  drive_on_chk: assert property (@(posedge clk) disable iff (rst)
    !drv_en_n |=> drive);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dout == ZERO) && !drive);
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         ab_pass,
  input  logic         ab_tick,
  input  logic         ab_tick_en_n,
  input  logic         ab_drv_en_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic [W-1:0] b_in,
  input  logic         ba_pass,
  input  logic         ba_tick,
  input  logic         ba_tick_en_n,
  input  logic         ba_drv_en_n,
  output logic [W-1:0] a_out,
  output logic         a_drive
);
  localparam int unsigned NPATH = 2;

  logic [NPATH-1:0][W-1:0] p_din, p_dout;
  logic [NPATH-1:0]        p_pass, p_tick, p_ten_n, p_den_n, p_drive;

  assign p_din[0]   = a_in;
  assign p_pass[0]  = ab_pass;
  assign p_tick[0]  = ab_tick;
  assign p_ten_n[0] = ab_tick_en_n;
  assign p_den_n[0] = ab_drv_en_n;
  assign p_din[1]   = b_in;
  assign p_pass[1]  = ba_pass;
  assign p_tick[1]  = ba_tick;
  assign p_ten_n[1] = ba_tick_en_n;
  assign p_den_n[1] = ba_drv_en_n;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    xcvr_lane #(.W(W)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .din       (p_din[g]),
      .pass      (p_pass[g]),
      .tick      (p_tick[g]),
      .tick_en_n (p_ten_n[g]),
      .drv_en_n  (p_den_n[g]),
      .dout      (p_dout[g]),
      .drive     (p_drive[g])
    );
  end

  assign b_out   = p_dout[0];
  assign b_drive = p_drive[0];
  assign a_out   = p_dout[1];
  assign a_drive = p_drive[1];

  // R6
  path_isolation_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_pass && ba_tick_en_n) |=> $stable(a_out));
endmodule

// File: tb/test_dual_path_xcvr.sv
module test_dual_path_xcvr;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_pass = 1'b0, ab_tick = 1'b0, ab_tick_en_n = 1'b1, ab_drv_en_n = 1'b1;
  logic ba_pass = 1'b0, ba_tick = 1'b0, ba_tick_en_n = 1'b1, ba_drv_en_n = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  dual_path_xcvr #(.W(W)) i_dual_path_xcvr (
    .clk(clk), .rst(rst),
    .a_in(a_in), .ab_pass(ab_pass), .ab_tick(ab_tick),
    .ab_tick_en_n(ab_tick_en_n), .ab_drv_en_n(ab_drv_en_n),
    .b_out(b_out), .b_drive(b_drive),
    .b_in(b_in), .ba_pass(ba_pass), .ba_tick(ba_tick),
    .ba_tick_en_n(ba_tick_en_n), .ba_drv_en_n(ba_drv_en_n),
    .a_out(a_out), .a_drive(a_drive)
  );

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc(); cyc();
    chk("R8 b_out", b_out, '0);
    chk("R8 a_out", a_out, '0);
    chk("R8 b_drive", W'(b_drive), '0);
    chk("R8 a_drive", W'(a_drive), '0);
    rst = 1'b0;
    cyc();
  endtask

  task automatic t_transparent();
    ab_pass = 1'b1; a_in = 18'h3FFFF;
    cyc(); chk("R1 R9 all ones", b_out, 18'h3FFFF);
    a_in = 18'h2AAAA; ab_tick = 1'b1; ab_tick_en_n = 1'b1;
    cyc(); chk("R1 R9 alternating", b_out, 18'h2AAAA);
    a_in = 18'h15555; ab_tick = 1'b0;
    cyc(); chk("R1 R9 inverse alternating", b_out, 18'h15555);
  endtask

  task automatic t_fall_hold();
    ab_pass = 1'b1; ab_tick = 1'b0; a_in = 18'h01234;
    cyc();
    ab_pass = 1'b0; a_in = 18'h3C3C3;
    cyc(); chk("R7 held after fall", b_out, 18'h01234);
    a_in = 18'h00F0F;
    cyc(); chk("R2 tick steady low", b_out, 18'h01234);
  endtask

  task automatic t_clocked();
    ab_tick_en_n = 1'b0; ab_tick = 1'b0;
    cyc();
    a_in = 18'h1BEEF; ab_tick = 1'b1;
    cyc(); chk("R3 rising tick capture", b_out, 18'h1BEEF);
    a_in = 18'h20001;
    cyc(); chk("R2 tick steady high", b_out, 18'h1BEEF);
    ab_tick = 1'b0;
    cyc(); chk("R2 falling tick", b_out, 18'h1BEEF);
  endtask

  task automatic t_gated();
    ab_tick_en_n = 1'b1; a_in = 18'h0ACE1;
    ab_tick = 1'b1;
    cyc(); chk("R4 gated rising tick", b_out, 18'h1BEEF);
    ab_tick = 1'b0;
    cyc(); chk("R4 still held", b_out, 18'h1BEEF);
  endtask

  task automatic t_collision();
    ab_pass = 1'b1; ab_tick = 1'b0; ab_tick_en_n = 1'b0; a_in = 18'h11111;
    cyc();
    ab_pass = 1'b0; ab_tick = 1'b1; a_in = 18'h22222;
    cyc(); chk("R7 fall with enabled rising tick", b_out, 18'h22222);
    ab_tick = 1'b0; ab_pass = 1'b1; ab_tick_en_n = 1'b1; a_in = 18'h33333;
    cyc();
    ab_pass = 1'b0; ab_tick = 1'b1; a_in = 18'h04444;
    cyc(); chk("R7 fall with gated rising tick", b_out, 18'h33333);
    ab_tick = 1'b0;
  endtask

  task automatic t_drive();
    ab_drv_en_n = 1'b0;
    cyc(); chk("R5 drive on", W'(b_drive), W'(1));
    chk("R6 other drive untouched", W'(a_drive), '0);
    ab_drv_en_n = 1'b1; ab_pass = 1'b1; a_in = 18'h00005;
    cyc(); chk("R5 drive off while passing", W'(b_drive), '0);
    ab_pass = 1'b0;
    cyc();
  endtask

  task automatic t_independent();
    ba_pass = 1'b1; b_in = 18'h2F00D; ba_drv_en_n = 1'b0;
    a_in = 18'h3FFFF;
    cyc();
    chk("R6 b_to_a passes", a_out, 18'h2F00D);
    chk("R6 a_to_b untouched", b_out, 18'h00005);
    chk("R6 b_to_a drive", W'(a_drive), W'(1));
    ba_pass = 1'b0; ba_tick_en_n = 1'b0; ab_pass = 1'b1; a_in = 18'h12121;
    cyc();
    chk("R6 b_to_a held", a_out, 18'h2F00D);
    chk("R6 a_to_b follows", b_out, 18'h12121);
    ab_pass = 1'b0;
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_fall_hold();
    t_clocked();
    t_gated();
    t_collision();
    t_drive();
    t_independent();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule